// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Receive Controller

This block handles the receive side of one bulk OUT endpoint in a full-speed USB device. The serial engine hands it the bytes of each OUT data packet, followed by an end-of-packet strobe that says whether the packet arrived intact. The block stores accepted packets in two ping-pong buffers. The serial engine can fill one buffer while the processor empties the other through a byte-wide data register.

An 8-bit control/status register shows the processor five things: whether a complete packet is held, whether unread bytes remain in the packet being drained, whether that packet is short (including zero length), whether a packet has completed, and the stall state. Firmware can force the endpoint to stall. A two-bit response code tells the handshake logic what to answer to an OUT token: ACK, NAK or STALL. Line coding, CRC, token decoding and handshake transmission are done outside this block.

Register bits: 0 service (a packet is held), 1 done (write 1 to clear), 2 avail (unread byte), 3 short, 4 force-stall (read/write), 5 stall-sent (write 1 to clear). Bits 7:6 always read 0. Response codes: 00 ACK, 01 NAK, 10 STALL.

Top module: `usb_out_ep_rx`

## Requirements
- R1: After reset the control/status register reads 0x00 and the response code is ACK (00).
- R2: A packet that ends with good status is stored. From the next cycle its bytes are returned through the data register (select=1, read strobe) in arrival order, one byte per read.
- R3: A packet that ends with bad status is discarded. It sets no status bit, and the next good packet takes the buffer it would have used.
- R4: Bit 3 (short) is 1 when the packet being drained holds fewer than MAX_PKT bytes, and 0 for a full-size packet.
- R5: Bit 3 changes only when the active packet is drained, or when a packet completes while no packet is held. On a drain it takes the short status of the next held packet, or 0 if no packet is held.
- R6: A zero-length packet shows bit 3 = 1 and bit 2 = 0. Writing 1 to bit 1 releases it.
- R7: Bit 2 (avail) is 1 while the active packet has an unread byte. A data read while bit 2 is 0 returns 0x00 and changes nothing.
- R8: Bit 0 (service) is 1 while one or more complete packets are held.
- R9: While both buffers hold packets and force-stall is 0, the response code is NAK (01), and packets that arrive are dropped.
- R10: Writing 1 to bit 4 makes the response code STALL (10) from the next cycle. Bit 4 reads back as written, and packets that arrive while it is set are dropped.
- R11: An OUT token (tok_out) while bit 4 is set sets bit 5. Writing 1 to bit 5 clears it. If the token and the clear fall in the same cycle, the set wins.
- R12: Bit 1 (done) sets the cycle after a good packet is stored and is cleared by writing 1 to it. If a packet completes in the same cycle as the clear, the set wins.
- R13: Bits 7:6 of the register always read 0, even after 1s are written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_vld | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe (carries no data) |
| rx_good | input | 1 | Packet status with rx_eop (1 = intact) |
| tok_out | input | 1 | OUT token seen (one-cycle pulse) |
| hs_code | output | 2 | Handshake to give: 00 ACK, 01 NAK, 10 STALL |
| cpu_sel | input | 1 | Register select: 0 control/status, 1 data |
| cpu_rd | input | 1 | Read strobe (pops a byte when cpu_sel=1) |
| cpu_wr | input | 1 | Write strobe (control/status only) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |

## Verification
Two pairs of events can fall in the same cycle. A packet can complete in the same cycle that firmware writes 1 to clear the done bit. An OUT token can arrive while stalling in the same cycle that firmware clears the stall-sent bit. The bench lines up the end-of-packet strobe with the register write, and the token with the write, on the same clock edge. In both cases it expects the bit to read 1 afterwards, because a set beats a clear. The same packet fills the second buffer, so the bench also checks the NAK code and that the short flag is reloaded from the waiting packet when the first one drains.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_code_e;

  localparam int unsigned NBUF = 2;

  localparam int unsigned B_SVC   = 0;
  localparam int unsigned B_DONE  = 1;
  localparam int unsigned B_AVAIL = 2;
  localparam int unsigned B_SHORT = 3;
  localparam int unsigned B_FST   = 4;
  localparam int unsigned B_SST   = 5;
endpackage

// File: rtl/usb_out_ep_rxbuf.sv
module usb_out_ep_rxbuf #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic [7:0]    wr_data,
  input  logic          wr_end,
  input  logic          wr_good,
  input  logic          wr_en,
  input  logic          rd_sel,
  input  logic [CW-1:0] rd_idx,
  input  logic          drain,
  output logic [7:0]    rd_data,
  output logic          rd_vld,
  output logic [CW-1:0] rd_len,
  output logic          nxt_vld,
  output logic [CW-1:0] nxt_len,
  output logic          full,
  output logic          commit,
  output logic [CW-1:0] commit_len
);
  import usb_out_ep_pkg::*;

  localparam int unsigned IW = $clog2(DEPTH);

  logic [7:0]    mem_q [NBUF][DEPTH];
  logic          vld_q [NBUF];
  logic          vld_d [NBUF];
  logic [CW-1:0] len_q [NBUF];
  logic [CW-1:0] len_d [NBUF];
  logic          wsel_q, wsel_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          take;
  logic          nsel;

  always_comb begin
    full       = vld_q[wsel_q];
    take       = wr_vld && !wr_end && wr_en && !full && (wcnt_q < CW'(MAX_PKT));
    commit     = wr_end && wr_good && wr_en && !full;
    commit_len = wcnt_q;
    wsel_d     = commit ? ~wsel_q : wsel_q;
    if (wr_end)    wcnt_d = '0;
    else if (take) wcnt_d = wcnt_q + 1'b1;
    else           wcnt_d = wcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      wsel_q <= wsel_d;
      wcnt_q <= wcnt_d;
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic hit_w;
    logic hit_r;

    always_comb begin
      hit_w    = commit && (wsel_q == 1'(b));
      hit_r    = drain && (rd_sel == 1'(b));
      vld_d[b] = (vld_q[b] | hit_w) & ~hit_r;
      len_d[b] = hit_w ? wcnt_q : len_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[b] <= 1'b0;
        len_q[b] <= '0;
      end else begin
        vld_q[b] <= vld_d[b];
        len_q[b] <= len_d[b];
      end
    end

    always_ff @(posedge clk) begin
      if (take && (wsel_q == 1'(b))) mem_q[b][wcnt_q[IW-1:0]] <= wr_data;
    end
  end

  always_comb begin
    nsel    = ~rd_sel;
    rd_data = mem_q[rd_sel][rd_idx[IW-1:0]];
    rd_vld  = vld_q[rd_sel];
    rd_len  = len_q[rd_sel];
    nxt_vld = vld_q[nsel];
    nxt_len = len_q[nsel];
  end
endmodule

// File: rtl/usb_out_ep_rdctl.sv
module usb_out_ep_rdctl #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic          rel_req,
  input  logic          rd_vld,
  input  logic [CW-1:0] rd_len,
  input  logic          nxt_vld,
  input  logic [CW-1:0] nxt_len,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  output logic          rd_sel,
  output logic [CW-1:0] rd_idx,
  output logic          avail,
  output logic          drain,
  output logic          short_flag
);
  logic          rsel_q, rsel_d;
  logic [CW-1:0] ridx_q, ridx_d;
  logic          rsp_q, rsp_d;
  logic          pop, last, zrel;

  always_comb begin
    avail = rd_vld && (ridx_q < rd_len);
    pop   = pop_req && avail;
    last  = pop && ((ridx_q + 1'b1) == rd_len);
    zrel  = rel_req && rd_vld && (rd_len == '0);
    drain = last | zrel;

    if (drain)    ridx_d = '0;
    else if (pop) ridx_d = ridx_q + 1'b1;
    else          ridx_d = ridx_q;

    rsel_d = drain ? ~rsel_q : rsel_q;

    rsp_d = rsp_q;
    if (drain) begin
      if (nxt_vld)     rsp_d = (nxt_len < CW'(MAX_PKT));
      else if (commit) rsp_d = (commit_len < CW'(MAX_PKT));
      else             rsp_d = 1'b0;
    end else if (commit && !rd_vld) begin
      rsp_d = (commit_len < CW'(MAX_PKT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= 1'b0;
      ridx_q <= '0;
      rsp_q  <= 1'b0;
    end else begin
      rsel_q <= rsel_d;
      ridx_q <= ridx_d;
      rsp_q  <= rsp_d;
    end
  end

  assign rd_sel     = rsel_q;
  assign rd_idx     = ridx_q;
  assign short_flag = rsp_q;
endmodule

// File: rtl/usb_out_ep_csr.sv
module usb_out_ep_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_wr,
  input  logic [7:0] wdata,
  input  logic       commit,
  input  logic       tok_out,
  input  logic       svc,
  input  logic       avail,
  input  logic       short_flag,
  input  logic       data_sel,
  input  logic [7:0] rd_byte,
  output logic       fst,
  output logic       sst,
  output logic       rpc,
  output logic       rel_req,
  output logic [7:0] rdata
);
  import usb_out_ep_pkg::*;

  logic fst_q, fst_d;
  logic sst_q, sst_d;
  logic rpc_q, rpc_d;
  logic [7:0] stat;

  always_comb begin
    rel_req = csr_wr && wdata[B_DONE];
    rpc_d   = commit | (rpc_q & ~rel_req);
    sst_d   = (tok_out & fst_q) | (sst_q & ~(csr_wr & wdata[B_SST]));
    fst_d   = csr_wr ? wdata[B_FST] : fst_q;

    stat          = 8'h00;
    stat[B_SVC]   = svc;
    stat[B_DONE]  = rpc_q;
    stat[B_AVAIL] = avail;
    stat[B_SHORT] = short_flag;
    stat[B_FST]   = fst_q;
    stat[B_SST]   = sst_q;

    if (data_sel) rdata = avail ? rd_byte : 8'h00;
    else          rdata = stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q <= 1'b0;
      sst_q <= 1'b0;
      rpc_q <= 1'b0;
    end else begin
      fst_q <= fst_d;
      sst_q <= sst_d;
      rpc_q <= rpc_d;
    end
  end

  assign fst = fst_q;
  assign sst = sst_q;
  assign rpc = rpc_q;
endmodule

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned MAX_PKT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_byte_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_eop,
  input  logic       rx_good,
  input  logic       tok_out,
  output logic [1:0] hs_code,
  input  logic       cpu_sel,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata
);
  import usb_out_ep_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          rst_s1, rst_n_s;
  logic [7:0]    rd_data;
  logic          rd_vld, nxt_vld, full, commit;
  logic [CW-1:0] rd_len, nxt_len, commit_len, rd_idx;
  logic          rd_sel, avail, drain, short_flag;
  logic          fst, sst, rpc, rel_req, svc;
  logic          csr_wr, pop_req;
  hs_code_e      hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  always_comb begin
    csr_wr  = cpu_wr && !cpu_sel;
    pop_req = cpu_rd && cpu_sel;
    svc     = rd_vld;
    if (fst)       hs = HS_STALL;
    else if (full) hs = HS_NAK;
    else           hs = HS_ACK;
    hs_code = hs;
  end

  usb_out_ep_rxbuf #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT), .CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n_s),
    .wr_vld(rx_byte_vld), .wr_data(rx_byte), .wr_end(rx_eop), .wr_good(rx_good),
    .wr_en(!fst),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .drain(drain),
    .rd_data(rd_data), .rd_vld(rd_vld), .rd_len(rd_len),
    .nxt_vld(nxt_vld), .nxt_len(nxt_len),
    .full(full), .commit(commit), .commit_len(commit_len)
  );

  usb_out_ep_rdctl #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT), .CW(CW)) u_rd (
    .clk(clk), .rst_n(rst_n_s),
    .pop_req(pop_req), .rel_req(rel_req),
    .rd_vld(rd_vld), .rd_len(rd_len), .nxt_vld(nxt_vld), .nxt_len(nxt_len),
    .commit(commit), .commit_len(commit_len),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .avail(avail), .drain(drain),
    .short_flag(short_flag)
  );

  usb_out_ep_csr u_csr (
    .clk(clk), .rst_n(rst_n_s),
    .csr_wr(csr_wr), .wdata(cpu_wdata), .commit(commit), .tok_out(tok_out),
    .svc(svc), .avail(avail), .short_flag(short_flag),
    .data_sel(cpu_sel), .rd_byte(rd_data),
    .fst(fst), .sst(sst), .rpc(rpc), .rel_req(rel_req), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/usb_out_ep_rx_chk.sv
module usb_out_ep_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_sel,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic       tok_out,
  input logic       rx_eop,
  input logic       rx_good,
  input logic [1:0] hs_code,
  input logic       fst,
  input logic       sst,
  input logic       rpc,
  input logic       svc,
  input logic       avail,
  input logic       short_flag,
  input logic       drain,
  input logic       commit
);
  // R10
  stall_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_sel && cpu_wdata[4]) |=> (hs_code == 2'b10));

  // R11
  stall_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_out && fst) |=> sst);

  // R12
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rpc);

  // R7
  avail_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> svc);

  // R9
  nak_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == 2'b01) |-> svc);

  // R5
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain && !commit) |=> $stable(short_flag));

  // R3
  bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && !rx_good && !drain) |=> (svc == $past(svc)));
endmodule

bind usb_out_ep_rx usb_out_ep_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .tok_out(tok_out), .rx_eop(rx_eop), .rx_good(rx_good),
  .hs_code(hs_code), .fst(fst), .sst(sst), .rpc(rpc), .svc(svc),
  .avail(avail), .short_flag(short_flag), .drain(drain), .commit(commit)
);

// File: tb/tb_usb_out_ep_rx.sv
`timescale 1ns/1ps
module tb_usb_out_ep_rx;
  logic       clk;
  logic       rst_n;
  logic       rx_byte_vld;
  logic [7:0] rx_byte;
  logic       rx_eop;
  logic       rx_good;
  logic       tok_out;
  logic [1:0] hs_code;
  logic       cpu_sel;
  logic       cpu_rd;
  logic       cpu_wr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  usb_out_ep_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .rx_good(rx_good), .tok_out(tok_out), .hs_code(hs_code),
    .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input int n, input logic good, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1'b1;
      rx_byte     = seed + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 1'b0;
    rx_eop      = 1'b1;
    rx_good     = good;
    @(negedge clk);
    rx_eop  = 1'b0;
    rx_good = 1'b0;
  endtask

  task automatic rd_csr(output logic [7:0] v);
    cpu_sel = 1'b0;
    #1;
    v = cpu_rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    cpu_sel = 1'b1;
    cpu_rd  = 1'b1;
    #1;
    v = cpu_rdata;
    @(negedge clk);
    cpu_rd  = 1'b0;
    cpu_sel = 1'b0;
  endtask

  task automatic wr_csr(input logic [7:0] v);
    cpu_sel   = 1'b0;
    cpu_wr    = 1'b1;
    cpu_wdata = v;
    @(negedge clk);
    cpu_wr    = 1'b0;
    cpu_wdata = 8'h00;
  endtask

  task automatic drain_check(input string tag, input int n, input logic [7:0] seed);
    logic [7:0] v;
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      rd_data(v);
      if (v !== seed + 8'(i)) bad++;
    end
    check(tag, 8'(bad), 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_csr(v);
    check("R1 csr after reset", v, 8'h00);
    check("R1 hs after reset", {6'd0, hs_code}, 8'h00);
  endtask

  task automatic t_full_pkt;
    logic [7:0] v;
    send_pkt(64, 1'b1, 8'h40);
    rd_csr(v);
    check("R2 R4 R8 R12 csr after full packet", v, 8'h07);
    drain_check("R2 full packet bytes", 64, 8'h40);
    rd_csr(v);
    check("R7 R8 csr after drain", v, 8'h02);
    wr_csr(8'h02);
    rd_csr(v);
    check("R12 done cleared", v, 8'h00);
  endtask

  task automatic t_short_pkt;
    logic [7:0] v;
    send_pkt(5, 1'b1, 8'h10);
    rd_csr(v);
    check("R4 short packet csr", v, 8'h0F);
    drain_check("R2 short packet bytes", 5, 8'h10);
    rd_csr(v);
    check("R5 short reset when none held", v, 8'h02);
    rd_data(v);
    check("R7 empty data read", v, 8'h00);
    wr_csr(8'h02);
  endtask

  task automatic t_bad_pkt;
    logic [7:0] v;
    send_pkt(10, 1'b0, 8'h90);
    rd_csr(v);
    check("R3 bad packet no status", v, 8'h00);
    send_pkt(3, 1'b1, 8'h30);
    rd_csr(v);
    check("R3 good after bad csr", v, 8'h0F);
    drain_check("R3 good after bad bytes", 3, 8'h30);
    wr_csr(8'h02);
  endtask

  task automatic t_order;
    logic [7:0] v;
    send_pkt(64, 1'b1, 8'h00);
    send_pkt(3, 1'b1, 8'h80);
    check("R9 hs NAK both held", {6'd0, hs_code}, 8'h01);
    send_pkt(4, 1'b1, 8'hC0);
    rd_csr(v);
    check("R4 full active csr", v, 8'h07);
    drain_check("R2 first packet bytes but last", 63, 8'h00);
    rd_csr(v);
    check("R5 short held until drained", v, 8'h07);
    rd_data(v);
    check("R2 last byte", v, 8'h3F);
    rd_csr(v);
    check("R5 short reloaded from waiting", v, 8'h0F);
    drain_check("R2 second packet bytes", 3, 8'h80);
    rd_csr(v);
    check("R9 third packet dropped", v, 8'h02);
    check("R9 hs ACK again", {6'd0, hs_code}, 8'h00);
    wr_csr(8'h02);
  endtask

  task automatic t_zlp;
    logic [7:0] v;
    send_pkt(0, 1'b1, 8'h00);
    rd_csr(v);
    check("R6 zero-length csr", v, 8'h0B);
    rd_data(v);
    check("R7 zero-length data read", v, 8'h00);
    rd_csr(v);
    check("R6 R7 read had no effect", v, 8'h0B);
    wr_csr(8'h02);
    rd_csr(v);
    check("R6 zero-length released", v, 8'h00);
  endtask

  task automatic t_stall;
    logic [7:0] v;
    wr_csr(8'h10);
    rd_csr(v);
    check("R10 force-stall readback", v, 8'h10);
    check("R10 hs STALL", {6'd0, hs_code}, 8'h02);
    send_pkt(4, 1'b1, 8'h55);
    rd_csr(v);
    check("R10 packet dropped while stalling", v, 8'h10);
    tok_out = 1'b1;
    @(negedge clk);
    tok_out = 1'b0;
    rd_csr(v);
    check("R11 stall-sent set", v, 8'h30);
    wr_csr(8'h30);
    rd_csr(v);
    check("R11 stall-sent cleared", v, 8'h10);
    tok_out   = 1'b1;
    cpu_wr    = 1'b1;
    cpu_wdata = 8'h30;
    @(negedge clk);
    tok_out   = 1'b0;
    cpu_wr    = 1'b0;
    cpu_wdata = 8'h00;
    rd_csr(v);
    check("R11 set beats clear", v, 8'h30);
    wr_csr(8'h20);
    rd_csr(v);
    check("R10 stall released", v, 8'h00);
    check("R10 hs ACK", {6'd0, hs_code}, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    send_pkt(2, 1'b1, 8'h10);
    for (int i = 0; i < 2; i++) begin
      rx_byte_vld = 1'b1;
      rx_byte     = 8'h20 + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 1'b0;
    rx_eop      = 1'b1;
    rx_good     = 1'b1;
    cpu_sel     = 1'b0;
    cpu_wr      = 1'b1;
    cpu_wdata   = 8'h02;
    @(negedge clk);
    rx_eop    = 1'b0;
    rx_good   = 1'b0;
    cpu_wr    = 1'b0;
    cpu_wdata = 8'h00;
    rd_csr(v);
    check("R12 done set beats clear", v, 8'h0F);
    check("R9 hs NAK after collide", {6'd0, hs_code}, 8'h01);
    drain_check("R2 collide first packet", 2, 8'h10);
    rd_csr(v);
    check("R5 short from second packet", v, 8'h0F);
    drain_check("R2 collide second packet", 2, 8'h20);
    wr_csr(8'h02);
    rd_csr(v);
    check("R12 collide cleanup", v, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    wr_csr(8'hC0);
    rd_csr(v);
    check("R13 reserved bits read zero", v, 8'h00);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_byte_vld = 1'b0; rx_byte = 8'h00; rx_eop = 1'b0;
    rx_good = 1'b0; tok_out = 1'b0; cpu_sel = 1'b0; cpu_rd = 1'b0;
    cpu_wr = 1'b0; cpu_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_pkt();
    t_short_pkt();
    t_bad_pkt();
    t_order();
    t_zlp();
    t_stall();
    t_collide();
    t_reserved();
    finish_run();
  end
endmodule